// File: doc/BRIEF.md
# Link Reset Notification Sequencer

This block tracks what happens below the port layer when a serial link resets. It receives single-cycle event strobes from the physical layer: a COMINIT detection, a loss of dword synchronization, completion of the COMSAS exchange, completion of speed negotiation and detection of a hard-reset primitive. When the link is torn down, it emits a fixed cascade of one-cycle notifications. A not-ready confirmation goes toward the link layer first. A phy-disabled confirmation and a link-disable message follow together. A connection-closed confirmation comes last. The confirmations reach the port layer in this order, so the port layer has already returned to idle before anything else arrives.

The block also decides when a hard-reset primitive may be reported. Recognition stays shut while the link re-initializes. It opens only after a COMINIT, a COMSAS exchange and a finished speed negotiation, in that order, and only after the whole teardown cascade has run. A primitive that arrives while recognition is shut is dropped and is not remembered. After reset the block starts with the link up and recognition open.

Top module: `link_reset_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, every notification output is low. The block starts with the link up and recognition open, so a hard-reset primitive in the first cycle after reset produces a report.
- R2: A COMINIT or sync-loss strobe while the link is up, or while waiting for COMSAS or speed negotiation, produces a one-cycle `not_ready_o` pulse in the next cycle. While waiting for COMINIT, a sync-loss strobe produces no pulse.
- R3: `phy_disabled_o` and `link_disable_o` pulse together exactly one cycle after each `not_ready_o` pulse, and at no other time.
- R4: `conn_closed_o` pulses exactly one cycle after each `link_disable_o` pulse, and at no other time.
- R5: After a teardown, the link returns to up only through COMINIT, then COMSAS completion, then speed completion. Strobes that arrive out of that order are ignored. A COMINIT or sync loss while waiting for COMSAS or speed restarts the recovery and issues a new `not_ready_o` pulse.
- R6: A hard-reset primitive that arrives while recognition is shut produces no report, either then or later.
- R7: While recognition is open, each hard-reset primitive produces a one-cycle `hard_reset_o` pulse in the next cycle. Recognition stays open until the next COMINIT or sync loss.
- R8: `hard_reset_o` never pulses between a `not_ready_o` pulse and the `conn_closed_o` pulse that completes its cascade.
- R9: If a hard-reset primitive and a COMINIT or sync-loss strobe arrive in the same cycle while the link is up, the teardown takes effect and no hard reset is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cominit_i | input | 1 | COMINIT detected strobe |
| sync_lost_i | input | 1 | Dword synchronization lost strobe |
| comsas_done_i | input | 1 | COMSAS exchange complete strobe |
| speed_done_i | input | 1 | Speed negotiation complete strobe |
| hard_prim_i | input | 1 | Hard-reset primitive detected strobe |
| not_ready_o | output | 1 | Phy-layer-not-ready confirmation pulse |
| phy_disabled_o | output | 1 | Phy-disabled confirmation pulse to port layer |
| link_disable_o | output | 1 | Link-disable message pulse to link control |
| conn_closed_o | output | 1 | Connection-closed confirmation pulse to port layer |
| hard_reset_o | output | 1 | Hard-reset-received confirmation pulse |

## Verification
The assertions take for granted that every input is a strobe sampled only at rising clock edges, that inputs are never X or Z once reset is released, and that reset is held high from time zero. Any input may be asserted in any cycle and in any combination, so no ordering is assumed among the events. The stimulus keeps inputs steady over each rising edge by changing them on falling edges, and it mixes weighted random strobes, including strobes held high for several cycles, with directed sequences that hit the fastest recovery path, out-of-order recovery strobes and simultaneous teardown and primitive.

// File: rtl/rns_pkg.sv
package rns_pkg;

    localparam int unsigned PHY_ST_W = 2;

    typedef enum logic [PHY_ST_W-1:0] {
        PHY_LINK_UP     = 2'd0,
        PHY_WAIT_INIT   = 2'd1,
        PHY_WAIT_COMSAS = 2'd2,
        PHY_WAIT_SPEED  = 2'd3
    } phy_st_e;

    typedef enum logic {
        ID_ACTIVE = 1'b0,
        ID_IDLE   = 1'b1
    } ident_st_e;

    typedef enum logic {
        CC_OPEN = 1'b0,
        CC_IDLE = 1'b1
    } conn_st_e;

    typedef struct packed {
        logic cominit;
        logic sync_lost;
        logic comsas_done;
        logic speed_done;
    } phy_evt_t;

    typedef struct packed {
        logic not_ready;
        logic phy_disabled;
        logic link_disable;
        logic conn_closed;
    } notify_t;

    function automatic logic is_teardown(input phy_evt_t ev);
        return ev.cominit | ev.sync_lost;
    endfunction

endpackage

// File: rtl/rns_phy_ctl.sv
module rns_phy_ctl
    import rns_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  phy_evt_t ev,
    output logic     not_ready_o,
    output logic     link_ready_o
);

    phy_st_e st_q, st_d;
    logic    nr_d, nr_q;

    always_comb begin
        st_d = st_q;
        nr_d = 1'b0;
        unique case (st_q)
            PHY_LINK_UP: begin
                if (is_teardown(ev)) begin
                    st_d = PHY_WAIT_INIT;
                    nr_d = 1'b1;
                end
            end
            PHY_WAIT_INIT: begin
                if (ev.cominit) st_d = PHY_WAIT_COMSAS;
            end
            PHY_WAIT_COMSAS: begin
                if (is_teardown(ev)) begin
                    st_d = PHY_WAIT_INIT;
                    nr_d = 1'b1;
                end else if (ev.comsas_done) begin
                    st_d = PHY_WAIT_SPEED;
                end
            end
            PHY_WAIT_SPEED: begin
                if (is_teardown(ev)) begin
                    st_d = PHY_WAIT_INIT;
                    nr_d = 1'b1;
                end else if (ev.speed_done) begin
                    st_d = PHY_LINK_UP;
                end
            end
            default: st_d = PHY_WAIT_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= PHY_LINK_UP;
            nr_q <= 1'b0;
        end else begin
            st_q <= st_d;
            nr_q <= nr_d;
        end
    end

    assign not_ready_o  = nr_q;
    assign link_ready_o = (st_q == PHY_LINK_UP);

    // R2: a not-ready pulse lasts exactly one cycle
    p_nr_single_r2: assert property (@(posedge clk) disable iff (rst)
        not_ready_o |=> !not_ready_o);

    // R2: waiting for COMINIT never yields a new not-ready pulse
    p_wait_init_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == PHY_WAIT_INIT) |=> !not_ready_o);

    // R5: link comes up only out of the speed wait
    p_up_after_speed_r5: assert property (@(posedge clk) disable iff (rst)
        (link_ready_o && !$past(link_ready_o)) |-> $past(st_q == PHY_WAIT_SPEED));

endmodule

// File: rtl/rns_ident_ctl.sv
module rns_ident_ctl
    import rns_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic not_ready_i,
    input  logic link_ready_i,
    output logic phy_disabled_o,
    output logic link_disable_o
);

    ident_st_e st_q;
    logic      pd_q, ld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ID_ACTIVE;
            pd_q <= 1'b0;
            ld_q <= 1'b0;
        end else begin
            pd_q <= not_ready_i;
            ld_q <= not_ready_i;
            if (not_ready_i)
                st_q <= ID_IDLE;
            else if (link_ready_i)
                st_q <= ID_ACTIVE;
        end
    end

    assign phy_disabled_o = pd_q;
    assign link_disable_o = ld_q;

    // R3: each not-ready pulse is followed by disable pair
    p_pd_follows_nr_r3: assert property (@(posedge clk) disable iff (rst)
        not_ready_i |=> (phy_disabled_o && link_disable_o));

    // R3: no disable pair without a preceding not-ready
    p_pd_needs_nr_r3: assert property (@(posedge clk) disable iff (rst)
        !not_ready_i |=> (!phy_disabled_o && !link_disable_o));

    // R3: the machine sits in idle after issuing the pair
    p_idle_after_nr_r3: assert property (@(posedge clk) disable iff (rst)
        phy_disabled_o |-> (st_q == ID_IDLE));

endmodule

// File: rtl/rns_conn_ctl.sv
module rns_conn_ctl
    import rns_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic link_disable_i,
    input  logic link_ready_i,
    output logic conn_closed_o
);

    conn_st_e st_q;
    logic     cc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= CC_OPEN;
            cc_q <= 1'b0;
        end else begin
            cc_q <= link_disable_i;
            if (link_disable_i)
                st_q <= CC_IDLE;
            else if (link_ready_i)
                st_q <= CC_OPEN;
        end
    end

    assign conn_closed_o = cc_q;

    // R4: each link-disable message is followed by connection-closed
    p_cc_follows_ld_r4: assert property (@(posedge clk) disable iff (rst)
        link_disable_i |=> conn_closed_o);

    // R4: connection-closed only after a link-disable
    p_cc_needs_ld_r4: assert property (@(posedge clk) disable iff (rst)
        !link_disable_i |=> !conn_closed_o);

    // R4: connection-closed is issued from idle
    p_cc_in_idle_r4: assert property (@(posedge clk) disable iff (rst)
        conn_closed_o |-> (st_q == CC_IDLE));

endmodule

// File: rtl/rns_hr_gate.sv
module rns_hr_gate
    import rns_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    link_ready_i,
    input  logic    teardown_i,
    input  logic    prim_i,
    input  notify_t notes_i,
    output logic    hard_reset_o
);

    logic pending_q;
    logic gate_open;
    logic hr_q;

    // teardown cascade in flight from not-ready until connection-closed
    always_ff @(posedge clk) begin
        if (rst)
            pending_q <= 1'b0;
        else if (notes_i.not_ready)
            pending_q <= 1'b1;
        else if (notes_i.conn_closed)
            pending_q <= 1'b0;
    end

    assign gate_open = link_ready_i && !pending_q
                    && !notes_i.not_ready && !notes_i.phy_disabled;

    always_ff @(posedge clk) begin
        if (rst)
            hr_q <= 1'b0;
        else
            hr_q <= prim_i && gate_open && !teardown_i;
    end

    assign hard_reset_o = hr_q;

    // R8: no report while the cascade is still running
    p_hr_after_chain_r8: assert property (@(posedge clk) disable iff (rst)
        hard_reset_o |-> (!pending_q && !notes_i.phy_disabled && !notes_i.conn_closed));

    // R7: a report needs a primitive in the cycle before
    p_hr_needs_prim_r7: assert property (@(posedge clk) disable iff (rst)
        hard_reset_o |-> $past(prim_i));

    // R5: a report is only made with the link up
    p_hr_link_up_r5: assert property (@(posedge clk) disable iff (rst)
        hard_reset_o |-> link_ready_i);

    // R9: teardown in the same cycle suppresses the report
    p_teardown_wins_r9: assert property (@(posedge clk) disable iff (rst)
        teardown_i |=> !hard_reset_o);

endmodule

// File: rtl/link_reset_sequencer.sv
module link_reset_sequencer
    import rns_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cominit_i,
    input  logic sync_lost_i,
    input  logic comsas_done_i,
    input  logic speed_done_i,
    input  logic hard_prim_i,
    output logic not_ready_o,
    output logic phy_disabled_o,
    output logic link_disable_o,
    output logic conn_closed_o,
    output logic hard_reset_o
);

    phy_evt_t ev;
    notify_t  notes;
    logic     link_ready;

    assign ev = '{cominit: cominit_i, sync_lost: sync_lost_i,
                  comsas_done: comsas_done_i, speed_done: speed_done_i};

    rns_phy_ctl u_phy (
        .clk          (clk),
        .rst          (rst),
        .ev           (ev),
        .not_ready_o  (notes.not_ready),
        .link_ready_o (link_ready)
    );

    rns_ident_ctl u_ident (
        .clk            (clk),
        .rst            (rst),
        .not_ready_i    (notes.not_ready),
        .link_ready_i   (link_ready),
        .phy_disabled_o (notes.phy_disabled),
        .link_disable_o (notes.link_disable)
    );

    rns_conn_ctl u_conn (
        .clk            (clk),
        .rst            (rst),
        .link_disable_i (notes.link_disable),
        .link_ready_i   (link_ready),
        .conn_closed_o  (notes.conn_closed)
    );

    rns_hr_gate u_gate (
        .clk          (clk),
        .rst          (rst),
        .link_ready_i (link_ready),
        .teardown_i   (is_teardown(ev)),
        .prim_i       (hard_prim_i),
        .notes_i      (notes),
        .hard_reset_o (hard_reset_o)
    );

    assign not_ready_o    = notes.not_ready;
    assign phy_disabled_o = notes.phy_disabled;
    assign link_disable_o = notes.link_disable;
    assign conn_closed_o  = notes.conn_closed;

    // R1: nothing is announced in the first cycle after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $fell(rst) |-> !(not_ready_o | phy_disabled_o | conn_closed_o | hard_reset_o));

endmodule

// File: tb/sim_link_reset_sequencer.sv
`timescale 1ns/1ps
module sim_link_reset_sequencer;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cominit_i = 0, sync_lost_i = 0, comsas_done_i = 0, speed_done_i = 0, hard_prim_i = 0;
    logic not_ready_o, phy_disabled_o, link_disable_o, conn_closed_o, hard_reset_o;

    always #2.5 clk = ~clk;

    link_reset_sequencer u0 (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    string ctx = "R7";

    // reference model: 0 up, 1 wait init, 2 wait comsas, 3 wait speed
    int  m_ph = 0;
    bit  m_nr = 0, m_pd = 0, m_cc = 0, m_hr = 0, m_pend = 0;

    function automatic bit gate_open(int ph, bit pend, bit nr, bit pd);
        return (ph == 0) && !pend && !nr && !pd;
    endfunction

    task automatic model_step(bit cm, bit sl, bit cs, bit sp, bit pr);
        bit td = cm | sl;
        int nph = m_ph;
        bit nnr = 0;
        bit nhr = pr && gate_open(m_ph, m_pend, m_nr, m_pd) && !td;
        case (m_ph)
            0: if (td) begin nph = 1; nnr = 1; end
            1: if (cm) nph = 2;
            2: if (td) begin nph = 1; nnr = 1; end else if (cs) nph = 3;
            default: if (td) begin nph = 1; nnr = 1; end else if (sp) nph = 0;
        endcase
        m_pend = m_nr ? 1'b1 : (m_cc ? 1'b0 : m_pend);
        m_cc = m_pd;
        m_pd = m_nr;
        m_nr = nnr;
        m_hr = nhr;
        m_ph = nph;
    endtask

    task automatic check1(string req, string what, logic act, bit exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check1("R2", "not_ready_o", not_ready_o, m_nr);
        check1("R3", "phy_disabled_o", phy_disabled_o, m_pd);
        check1("R3", "link_disable_o", link_disable_o, m_pd);
        check1("R4", "conn_closed_o", conn_closed_o, m_cc);
        check1(m_hr ? ctx : (ctx == "R7" ? "R6" : ctx), "hard_reset_o", hard_reset_o, m_hr);
    endtask

    // caller sits at a falling edge
    task automatic step(bit cm, bit sl, bit cs, bit sp, bit pr);
        cominit_i = cm; sync_lost_i = sl; comsas_done_i = cs;
        speed_done_i = sp; hard_prim_i = pr;
        @(posedge clk);
        model_step(cm, sl, cs, sp, pr);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1A2B3C));
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check1("R1", "not_ready_o in reset", not_ready_o, 0);
        check1("R1", "conn_closed_o in reset", conn_closed_o, 0);
        check1("R1", "hard_reset_o in reset", hard_reset_o, 0);
        rst = 1'b0;
        // R1: gate open straight out of reset
        ctx = "R1";
        step(0, 0, 0, 0, 1);
        ctx = "R7";
        step(0, 0, 0, 0, 1);            // R7 repeat while open
        idle(2);

        // R2/R3/R4 cascade with primitives during teardown (R6)
        ctx = "R6";
        step(0, 1, 0, 0, 1);
        step(0, 1, 0, 0, 1);            // sync lost held in init wait: no pulse
        step(0, 0, 1, 1, 1);            // out of order strobes ignored (R5)
        step(0, 0, 0, 0, 1);
        // fastest recovery, primitive every cycle (R8)
        ctx = "R8";
        step(1, 0, 0, 0, 1);
        step(0, 0, 1, 0, 1);
        step(0, 0, 0, 1, 1);
        ctx = "R7";
        step(0, 0, 0, 0, 1);
        idle(2);
        // R6: primitive before gate opens is not queued
        ctx = "R6";
        step(1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        step(1, 0, 0, 0, 1);
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0);
        idle(3);
        // R5: restart from speed wait issues a new not-ready
        ctx = "R5";
        step(0, 1, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        step(1, 0, 0, 0, 0);
        idle(3);
        step(1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0);
        idle(2);
        // R9: teardown and primitive together
        ctx = "R9";
        step(1, 0, 0, 0, 1);
        idle(3);
        step(1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0);
        step(0, 1, 0, 0, 1);
        idle(3);

        // constrained random mix
        ctx = "R7";
        for (int i = 0; i < 4000; i++) begin
            bit cm = ($urandom_range(99) < 6);
            bit sl = ($urandom_range(99) < 3);
            bit cs = ($urandom_range(99) < 35);
            bit sp = ($urandom_range(99) < 35);
            bit pr = ($urandom_range(99) < 25);
            step(cm, sl, cs, sp, pr);
        end
        finish_run();
    end

endmodule